// File: doc/BRIEF.md
# Single-Channel Memory-Described DMA Engine

This block moves a run of data items from one memory region to another. Its settings are not held in local registers. They live in a small control entry in system memory, and the engine reads that entry each time it is started. The entry has three words: the inclusive last address of the source, the inclusive last address of the destination, and a packed control word. The control word gives the item size, the two address increments, the item count, the group length and the operating mode. The engine reaches the entry through the same memory master port it uses for data.

A start request makes the engine fetch the entry, check that the settings are consistent, and then copy items one at a time, reading each one and then writing it. It works backwards from the end pointers: an item's address is the end pointer minus the number of items still to follow it, shifted by the increment code. After each group it writes the count still outstanding back into the control word in memory. In the single-group mode, the next start request therefore carries on from where the last one stopped. In the free-running mode, one start request carries the whole transfer through to the end. When the final item has been written, the mode field is written back as stop and a one-cycle done pulse is raised.

The memory master port is a valid/ready request channel paired with a read-response strobe. While a request is presented and ready is low, the engine holds the address, direction, size and write data unchanged. The request completes in the cycle where valid and ready are both high. Writes receive no response. Each read expects exactly one response beat, no earlier than the cycle after its handshake. The engine always accepts that beat and never has more than one read outstanding.

Top module: `dma_chan_engine`

## Requirements
- R1: On a start request while idle, the engine issues three word-sized reads in this order: entry+0x0 (source end), entry+0x4 (destination end), entry+0x8 (control). The entry address is `table_base + CHAN_IDX*0x10`, plus 0x200 when `use_alt` is high at the request.
- R2: The control word is decoded as follows:
  - bits 31:30 destination increment
  - bits 29:28 destination size
  - bits 27:26 source increment
  - bits 25:24 source size
  - bits 17:14 group code
  - bits 13:4 item count minus one
  - bits 2:0 mode

  Item k of N (k counted from 0) is read at `src_end - ((N-1-k) << src_inc)` and written at `dst_end - ((N-1-k) << dst_inc)`. An increment code of 3 keeps the end pointer unchanged for every item.
- R3: Size codes are 0 = byte, 1 = halfword and 2 = word. Every item read and write uses the configured item size. Each item is read before it is written, and the written value equals the bytes read.
- R4: A group holds 2^code items, and codes 10 to 15 all mean 1024 items. A group is cut short when fewer items remain. In mode 1 (single-group), one start request moves exactly one group and then returns to idle without a done pulse if items remain.
- R5: After every group the engine writes the control word back to entry+0x8. The write-back has the count field set to the remaining items minus one, bits 23:18 forced to zero, and all other fields unchanged.
- R6: When the last item is written, the write-back carries mode 0 and count 0. `done` then pulses high for exactly one cycle, in the cycle after that write-back handshake.
- R7: In mode 2 (free-running), one start request runs every group back to back without refetching the entry, writing back once per group and pulsing `done` once.
- R8: Mode 0 (stop) performs no memory access after the three entry reads and raises neither `done` nor `cfg_err`.
- R9: Any of the following raises a one-cycle `cfg_err` pulse, with no data access and no write-back after the entry reads:
  - a mode from 3 to 7
  - source size not equal to destination size
  - size code 3
  - an increment code other than 3 that is smaller than the size code
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the next cycle keeps valid high and keeps address, write flag, size and write data stable.
- R11: A start request that arrives while the engine is not idle is ignored: it produces no extra access and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Start request, sampled only while idle |
| table_base | input | AW | Base address of the control table |
| use_alt | input | 1 | Selects the alternate entry (+0x200) for this start |
| done | output | 1 | One-cycle pulse when the transfer has completed |
| cfg_err | output | 1 | One-cycle pulse on an invalid configuration |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address |
| mem_req_size | output | 2 | Access size code (0 byte, 1 half, 2 word) |
| mem_req_wdata | output | DW | Write data, right-aligned |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_rdata | input | DW | Read data, right-aligned |

## Verification
The assertions assume that the memory side delivers exactly one response per accepted read, no earlier than the cycle after the handshake, and never sends a response while no read is outstanding. The bench memory model meets these assumptions by construction: it answers each accepted read on the following edge and creates no other beats. Its ready line follows a pseudo-random pattern, so the hold rule is exercised under stalls. The assertions also assume that `start_req` is a plain level sampled at the clock. The bench drives it only on falling edges and holds it for whole cycles.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef struct packed {
    logic [1:0] dst_inc;
    logic [1:0] dst_sz;
    logic [1:0] src_inc;
    logic [1:0] src_sz;
    logic [5:0] rsvd;
    logic [3:0] grp_code;
    logic [9:0] cnt_m1;
    logic       nxt_burst;
    logic [2:0] mode;
  } ctl_word_t;

  localparam logic [2:0] MODE_STOP  = 3'd0;
  localparam logic [2:0] MODE_BASIC = 3'd1;
  localparam logic [2:0] MODE_AUTO  = 3'd2;

  localparam logic [1:0] INC_NONE = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH_REQ,
    S_FETCH_WAIT,
    S_CHECK,
    S_RD_REQ,
    S_RD_WAIT,
    S_WR_REQ,
    S_WB_REQ
  } eng_state_t;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dma_ctl_check.sv
module dma_ctl_check #(
  parameter int CW = 11
) (
  input  logic [1:0]    src_sz,
  input  logic [1:0]    dst_sz,
  input  logic [1:0]    src_inc,
  input  logic [1:0]    dst_inc,
  input  logic [3:0]    grp_code,
  input  logic [2:0]    mode,
  output logic          is_stop,
  output logic          is_auto,
  output logic          cfg_bad,
  output logic [CW-1:0] grp_len
);
  import dma_pkg::*;

  localparam int          CAP_CODE = CW - 1;
  localparam logic [3:0]  CAP_C4   = 4'(CAP_CODE);

  logic [3:0] code_eff;
  logic       size_bad;
  logic       inc_bad;
  logic       mode_bad;

  always_comb begin
    code_eff = (grp_code > CAP_C4) ? CAP_C4 : grp_code;
    grp_len  = CW'(1) << code_eff;
    is_stop  = (mode == MODE_STOP);
    is_auto  = (mode == MODE_AUTO);
    mode_bad = (mode != MODE_BASIC) && (mode != MODE_AUTO);
    size_bad = (src_sz != dst_sz) || (src_sz == 2'd3);
    inc_bad  = ((src_inc != INC_NONE) && (src_inc < src_sz)) ||
               ((dst_inc != INC_NONE) && (dst_inc < dst_sz));
    cfg_bad  = mode_bad || size_bad || inc_bad;
  end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 11
) (
  input  logic [AW-1:0] end_ptr,
  input  logic [1:0]    inc,
  input  logic [CW-1:0] remaining,
  output logic [AW-1:0] addr
);
  import dma_pkg::*;

  logic [AW-1:0] back_items;
  logic [AW-1:0] back_bytes;

  always_comb begin
    back_items = AW'(remaining - CW'(1));
    back_bytes = back_items << inc;
    addr       = (inc == INC_NONE) ? end_ptr : (end_ptr - back_bytes);
  end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int CHAN_IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic [AW-1:0] table_base,
  input  logic          use_alt,
  output logic          done,
  output logic          cfg_err,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [1:0]    mem_req_size,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);
  import dma_pkg::*;

  localparam int          CNT_W      = 10;
  localparam int          CW         = CNT_W + 1;
  localparam logic [AW-1:0] STRIDE   = AW'(16);
  localparam logic [AW-1:0] ALT_OFS  = AW'(32'h200);
  localparam logic [AW-1:0] CHAN_OFS = AW'(CHAN_IDX) * STRIDE;
  localparam logic [1:0]  WORD_SZ    = 2'd2;

  eng_state_t    state_q;
  logic [1:0]    fidx_q;
  logic [AW-1:0] entry_q;
  logic [AW-1:0] src_end_q;
  logic [AW-1:0] dst_end_q;
  ctl_word_t     ctl_q;
  logic [CW-1:0] rem_q;
  logic [CW-1:0] grp_q;
  logic [DW-1:0] data_q;
  logic          done_q;
  logic          err_q;

  logic          is_stop;
  logic          is_auto;
  logic          cfg_bad;
  logic [CW-1:0] grp_len;
  logic [AW-1:0] src_addr;
  logic [AW-1:0] dst_addr;
  logic [CW-1:0] total_cnt;
  logic [CW-1:0] first_grp;
  logic [CW-1:0] next_grp;
  ctl_word_t     wb_word;
  logic          hs;
  logic [DW-1:0] item_mask;

  dma_ctl_check #(.CW(CW)) u_check (
    .src_sz   (ctl_q.src_sz),
    .dst_sz   (ctl_q.dst_sz),
    .src_inc  (ctl_q.src_inc),
    .dst_inc  (ctl_q.dst_inc),
    .grp_code (ctl_q.grp_code),
    .mode     (ctl_q.mode),
    .is_stop  (is_stop),
    .is_auto  (is_auto),
    .cfg_bad  (cfg_bad),
    .grp_len  (grp_len)
  );

  dma_addr_gen #(.AW(AW), .CW(CW)) u_src_addr (
    .end_ptr   (src_end_q),
    .inc       (ctl_q.src_inc),
    .remaining (rem_q),
    .addr      (src_addr)
  );

  dma_addr_gen #(.AW(AW), .CW(CW)) u_dst_addr (
    .end_ptr   (dst_end_q),
    .inc       (ctl_q.dst_inc),
    .remaining (rem_q),
    .addr      (dst_addr)
  );

  always_comb begin
    total_cnt = CW'(ctl_q.cnt_m1) + CW'(1);
    first_grp = (grp_len < total_cnt) ? grp_len : total_cnt;
    next_grp  = (grp_len < rem_q) ? grp_len : rem_q;
    item_mask = DW'(size_mask(ctl_q.src_sz));
    wb_word   = ctl_q;
    if (rem_q == '0) begin
      wb_word.cnt_m1 = '0;
      wb_word.mode   = MODE_STOP;
    end else begin
      wb_word.cnt_m1 = CNT_W'(rem_q - CW'(1));
    end
  end

  // request channel: every field comes from registered state only
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_size  = WORD_SZ;
    mem_req_wdata = '0;
    case (state_q)
      S_FETCH_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = entry_q + AW'({fidx_q, 2'b00});
      end
      S_RD_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = src_addr;
        mem_req_size  = ctl_q.src_sz;
      end
      S_WR_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = dst_addr;
        mem_req_size  = ctl_q.dst_sz;
        mem_req_wdata = data_q;
      end
      S_WB_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = entry_q + AW'(8);
        mem_req_wdata = DW'(wb_word);
      end
      default: ;
    endcase
  end

  assign hs = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      fidx_q    <= '0;
      entry_q   <= '0;
      src_end_q <= '0;
      dst_end_q <= '0;
      ctl_q     <= '0;
      rem_q     <= '0;
      grp_q     <= '0;
      data_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_req) begin
            entry_q <= table_base + CHAN_OFS + (use_alt ? ALT_OFS : '0);
            fidx_q  <= '0;
            state_q <= S_FETCH_REQ;
          end
        end
        S_FETCH_REQ: begin
          if (hs) state_q <= S_FETCH_WAIT;
        end
        S_FETCH_WAIT: begin
          if (mem_rsp_valid) begin
            case (fidx_q)
              2'd0:    src_end_q <= AW'(mem_rsp_rdata);
              2'd1:    dst_end_q <= AW'(mem_rsp_rdata);
              default: begin
                ctl_q      <= ctl_word_t'(mem_rsp_rdata);
                ctl_q.rsvd <= '0;
              end
            endcase
            if (fidx_q == 2'd2) begin
              state_q <= S_CHECK;
            end else begin
              fidx_q  <= fidx_q + 2'd1;
              state_q <= S_FETCH_REQ;
            end
          end
        end
        S_CHECK: begin
          if (is_stop) begin
            state_q <= S_IDLE;
          end else if (cfg_bad) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            rem_q   <= total_cnt;
            grp_q   <= first_grp;
            state_q <= S_RD_REQ;
          end
        end
        S_RD_REQ: begin
          if (hs) state_q <= S_RD_WAIT;
        end
        S_RD_WAIT: begin
          if (mem_rsp_valid) begin
            data_q  <= mem_rsp_rdata & item_mask;
            state_q <= S_WR_REQ;
          end
        end
        S_WR_REQ: begin
          if (hs) begin
            rem_q <= rem_q - CW'(1);
            grp_q <= grp_q - CW'(1);
            if (rem_q == CW'(1) || grp_q == CW'(1)) state_q <= S_WB_REQ;
            else                                     state_q <= S_RD_REQ;
          end
        end
        S_WB_REQ: begin
          if (hs) begin
            if (rem_q == '0) begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end else if (is_auto) begin
              grp_q   <= next_grp;
              state_q <= S_RD_REQ;
            end else begin
              state_q <= S_IDLE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done    = done_q;
  assign cfg_err = err_q;

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          cfg_err,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [1:0]    mem_req_size,
  input logic [DW-1:0] mem_req_wdata
);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
       $stable(mem_req_size) && $stable(mem_req_wdata)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req_valid && mem_req_ready && mem_req_write));

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !cfg_err);

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !mem_req_valid);

  p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && cfg_err));

  p_size_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_size != 2'd3));

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .done          (done),
  .cfg_err       (cfg_err),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_size  (mem_req_size),
  .mem_req_wdata (mem_req_wdata)
);

// File: tb/dma_chan_engine_tb_top.sv
module dma_chan_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CHAN       = 2;
  localparam int SRC_BASE   = 32'h400;
  localparam int DST_BASE   = 32'h800;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic [31:0] table_base = '0;
  logic        use_alt = 1'b0;
  logic        done, cfg_err;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  int checks = 0;
  int failures = 0;

  logic [7:0]  mem [0:4095];
  logic        bw_en = 1'b0;
  logic [11:0] bw_addr = '0;
  logic [7:0]  bw_byte = '0;
  logic        log_clr = 1'b0;
  int          log_n = 0;
  int          done_n = 0;
  int          err_n = 0;
  logic [31:0] log_addr [0:63];
  logic        log_wr   [0:63];
  logic [1:0]  log_sz   [0:63];
  logic        stall_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_engine #(.AW(32), .DW(32), .CHAN_IDX(CHAN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .table_base(table_base),
    .use_alt(use_alt), .done(done), .cfg_err(cfg_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // memory model: sole writer of mem and of the logs
  always @(posedge clk) begin
    logic [11:0] a;
    logic [31:0] rd;
    mem_rsp_valid <= 1'b0;
    if (bw_en) mem[bw_addr] <= bw_byte;
    if (log_clr) begin
      log_n <= 0; done_n <= 0; err_n <= 0;
    end else begin
      if (done) done_n <= done_n + 1;
      if (cfg_err) err_n <= err_n + 1;
      if (mem_req_valid && mem_req_ready) begin
        a = mem_req_addr[11:0];
        if (log_n < 64) begin
          log_addr[log_n] <= mem_req_addr;
          log_wr[log_n]   <= mem_req_write;
          log_sz[log_n]   <= mem_req_size;
        end
        log_n <= log_n + 1;
        if (mem_req_write) begin
          mem[a] <= mem_req_wdata[7:0];
          if (mem_req_size >= 2'd1) mem[a+12'd1] <= mem_req_wdata[15:8];
          if (mem_req_size == 2'd2) begin
            mem[a+12'd2] <= mem_req_wdata[23:16];
            mem[a+12'd3] <= mem_req_wdata[31:24];
          end
        end else begin
          rd = {mem[a+12'd3], mem[a+12'd2], mem[a+12'd1], mem[a]};
          if (mem_req_size == 2'd0) rd = rd & 32'hFF;
          if (mem_req_size == 2'd1) rd = rd & 32'hFFFF;
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= rd;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_req_ready = stall_on ? lfsr[0] : 1'b1;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input int addr, input logic [7:0] b);
    @(negedge clk);
    bw_en = 1'b1; bw_addr = addr[11:0]; bw_byte = b;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic poke32(input int addr, input logic [31:0] w);
    for (int b = 0; b < 4; b++) poke(addr + b, w[8*b +: 8]);
  endtask

  function automatic logic [31:0] peek32(input int addr);
    return {mem[(addr+3) & 12'hFFF], mem[(addr+2) & 12'hFFF],
            mem[(addr+1) & 12'hFFF], mem[addr & 12'hFFF]};
  endfunction

  function automatic logic [31:0] mk_ctl(input int di, input int dsz, input int si,
      input int ssz, input int rsv, input int grp, input int cnt_m1, input int md);
    return {di[1:0], dsz[1:0], si[1:0], ssz[1:0], rsv[5:0], grp[3:0],
            cnt_m1[9:0], 1'b0, md[2:0]};
  endfunction

  task automatic clr_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
  endtask

  task automatic wait_end(input int lim);
    for (int c = 0; c < lim; c++) begin
      @(negedge clk);
      if (done_n + err_n > 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  function automatic int entry_of(input int base, input bit alt);
    return base + CHAN * 16 + (alt ? 32'h200 : 0);
  endfunction

  task automatic check_fetch(input int ent, input string tag);
    bit ok = (log_n >= 3);
    for (int i = 0; i < 3; i++)
      if (ok && (log_addr[i] != ent + 4*i || log_wr[i] || log_sz[i] != 2'd2)) ok = 0;
    chk(ok, tag, "entry fetch order", log_addr[0], ent);
  endtask

  // one copy run in free-running mode from the primary entry (base 0)
  task automatic run_copy(input int s, input int si, input int di, input int n, input int grp);
    int ent = entry_of(0, 0);
    int se = SRC_BASE + ((si == 3) ? 0 : (n - 1) << si);
    int de = DST_BASE + ((di == 3) ? 0 : (n - 1) << di);
    logic [7:0] expd [0:15];
    int bytes = 1 << s;
    int ngrp = (n + (1 << grp) - 1) >> grp;
    int wb = 0;
    bit ok;
    for (int i = 0; i < 16; i++) begin expd[i] = 8'h00; poke(DST_BASE + i, 8'h00); end
    for (int k = 0; k < n; k++) begin
      int sa = (si == 3) ? se : se - ((n - 1 - k) << si);
      int da = (di == 3) ? de : de - ((n - 1 - k) << di);
      for (int b = 0; b < bytes; b++) expd[da - DST_BASE + b] = mem[sa + b];
    end
    table_base = 0; use_alt = 0;
    poke32(ent, se); poke32(ent + 4, de);
    poke32(ent + 8, mk_ctl(di, s, si, s, 6'h2A, grp, n - 1, 2));
    clr_log();
    pulse_start();
    wait_end(400);
    check_fetch(ent, "R1");
    ok = 1;
    for (int i = 0; i < 16; i++) if (mem[DST_BASE + i] != expd[i]) ok = 0;
    chk(ok, "R2", $sformatf("dst bytes s=%0d si=%0d di=%0d n=%0d", s, si, di, n),
        peek32(DST_BASE), {expd[3], expd[2], expd[1], expd[0]});
    ok = 1;
    for (int i = 3; i < log_n && i < 64; i++) begin
      if (log_addr[i] == ent + 8) wb++;
      else if (log_sz[i] != s[1:0]) ok = 0;
    end
    chk(ok, "R3", "item access size", s, s);
    chk(wb == ngrp, "R7", "write-backs per run", wb, ngrp);
    chk(done_n == 1 && err_n == 0, "R6", "done pulses", done_n, 1);
    chk(peek32(ent + 8) == mk_ctl(di, s, si, s, 0, grp, 0, 0), "R5",
        "final control word", peek32(ent + 8), mk_ctl(di, s, si, s, 0, grp, 0, 0));
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > WATCHDOG) begin
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int ent;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !cfg_err && !mem_req_valid, "R6", "reset outputs idle",
        {done, cfg_err, mem_req_valid}, 0);
    for (int i = 0; i < 64; i++) poke(SRC_BASE + i, 8'((i * 37 + 11) ^ 8'h5A));
    stall_on = 1'b1;

    // sweep over sizes, increments and counts (R2, R3, R5, R6, R7)
    for (int s = 0; s < 3; s++)
      for (int si = s; si < 4; si++)
        for (int di = s; di < 4; di++)
          for (int nsel = 0; nsel < 2; nsel++)
            run_copy(s, si, di, nsel ? 3 : 1, 1);

    // R4/R5: single-group mode, 5 words, groups of 2
    ent = entry_of(0, 0);
    poke32(ent, SRC_BASE + 16); poke32(ent + 4, DST_BASE + 16);
    poke32(ent + 8, mk_ctl(2, 2, 2, 2, 0, 1, 4, 1));
    clr_log(); pulse_start(); repeat (80) @(negedge clk);
    chk(done_n == 0, "R4", "no done after first group", done_n, 0);
    chk(peek32(ent + 8) == mk_ctl(2, 2, 2, 2, 0, 1, 2, 1), "R5",
        "count after group 1", peek32(ent + 8), mk_ctl(2, 2, 2, 2, 0, 1, 2, 1));
    chk(log_n == 3 + 4 + 1, "R4", "accesses in one group", log_n, 8);
    clr_log(); pulse_start(); repeat (80) @(negedge clk);
    chk(peek32(ent + 8) == mk_ctl(2, 2, 2, 2, 0, 1, 0, 1), "R5",
        "count after group 2", peek32(ent + 8), mk_ctl(2, 2, 2, 2, 0, 1, 0, 1));
    clr_log(); pulse_start(); repeat (80) @(negedge clk);
    chk(done_n == 1 && log_n == 3 + 2 + 1, "R4", "last short group", log_n, 6);
    chk(peek32(DST_BASE) == peek32(SRC_BASE) && peek32(DST_BASE + 16) == peek32(SRC_BASE + 16),
        "R2", "basic mode data", peek32(DST_BASE + 16), peek32(SRC_BASE + 16));

    // R4: group code above 10 covers a 12-item transfer in one request
    poke32(ent, SRC_BASE + 11); poke32(ent + 4, DST_BASE + 11);
    poke32(ent + 8, mk_ctl(0, 0, 0, 0, 0, 12, 11, 1));
    clr_log(); pulse_start(); wait_end(600);
    chk(done_n == 1 && log_n == 3 + 24 + 1, "R4", "large group code", log_n, 28);

    // R8: stop mode does nothing after the fetch
    poke32(ent + 8, mk_ctl(2, 2, 2, 2, 0, 1, 3, 0));
    clr_log(); pulse_start(); repeat (60) @(negedge clk);
    chk(log_n == 3 && done_n == 0 && err_n == 0, "R8", "stop mode accesses", log_n, 3);

    // R9: bad configurations
    poke32(ent + 8, mk_ctl(2, 2, 2, 1, 0, 1, 3, 2));
    clr_log(); pulse_start(); repeat (60) @(negedge clk);
    chk(err_n == 1 && log_n == 3 && done_n == 0, "R9", "size mismatch", log_n, 3);
    poke32(ent + 8, mk_ctl(0, 1, 1, 1, 0, 1, 3, 2));
    clr_log(); pulse_start(); repeat (60) @(negedge clk);
    chk(err_n == 1 && log_n == 3, "R9", "increment below size", log_n, 3);
    poke32(ent + 8, mk_ctl(2, 2, 2, 2, 0, 1, 3, 3));
    clr_log(); pulse_start(); repeat (60) @(negedge clk);
    chk(err_n == 1 && log_n == 3, "R9", "unsupported mode", err_n, 1);
    poke32(ent + 8, mk_ctl(3, 3, 3, 3, 0, 1, 3, 1));
    clr_log(); pulse_start(); repeat (60) @(negedge clk);
    chk(err_n == 1 && log_n == 3, "R9", "size code 3", err_n, 1);

    // R1: alternate entry with a non-zero table base
    ent = entry_of(32'h100, 1);
    poke32(ent, SRC_BASE); poke32(ent + 4, DST_BASE);
    poke32(ent + 8, mk_ctl(2, 2, 2, 2, 0, 0, 0, 2));
    table_base = 32'h100; use_alt = 1'b1;
    clr_log(); pulse_start(); wait_end(200);
    check_fetch(32'h320, "R1");
    chk(done_n == 1 && peek32(32'h328) == mk_ctl(2, 2, 2, 2, 0, 0, 0, 0), "R6",
        "alternate entry completion", peek32(32'h328), mk_ctl(2, 2, 2, 2, 0, 0, 0, 0));

    // R11 + R7: start pulses during a free-running run are ignored
    table_base = 0; use_alt = 1'b0;
    ent = entry_of(0, 0);
    poke32(ent, SRC_BASE + 28); poke32(ent + 4, DST_BASE + 28);
    poke32(ent + 8, mk_ctl(2, 2, 2, 2, 0, 0, 7, 2));
    clr_log(); pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    wait_end(800);
    repeat (60) @(negedge clk);
    chk(done_n == 1 && log_n == 3 + 16 + 8, "R11", "busy start ignored", log_n, 27);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule